// File: doc/BRIEF.md
# Clock Phase Alignment Controller

This block steers an internal clock into phase with an incoming reference clock. A flip-flop clocked by the internal clock samples the reference clock, and that one bit comes into this block. When the internal edge sits well before the reference edge, the sample is always low. When it sits well after, the sample is always high. When the two edges coincide, clock jitter makes the sample a random mix.

The block passes the bit through a two-stage synchronizer. It then counts the high samples over a fixed window of internal-clock cycles. Too many highs makes it request one phase step toward an earlier edge. Too few highs makes it request one step toward a later edge. A count inside a balanced band declares alignment.

Steps are requested from a clock manager's dynamic phase-shift port. The block gives a one-cycle request pulse and a direction bit, then waits for the manager's done strobe before it opens the next window. A signed total of the steps applied is kept and saturates at a limit. A small dither of one step around the aligned point is expected in steady state.

Top module: `phase_align_ctrl`

## Requirements
- R1: Each measurement window covers exactly WIN_LEN consecutive counted cycles, and its count is the number of those cycles whose synchronized sample was high. A reference pattern that repeats every WIN_LEN cycles with k high cycles therefore yields a count of k.
- R2: A window count above HI_TH produces a one-cycle `ps_step` with `ps_later` = 0 (toward an earlier edge), and `step_total` decreases by one.
- R3: A window count below LO_TH produces a one-cycle `ps_step` with `ps_later` = 1 (toward a later edge), and `step_total` increases by one.
- R4: A window count from LO_TH to HI_TH inclusive issues no step and drives `aligned` high from the cycle after the window ends.
- R5: `ps_step` is never high for two consecutive cycles.
- R6: After a step, no further window is counted and no step is issued until `ps_done` is seen high. Samples taken during that wait are discarded. `ps_done` has no effect while a window is being counted.
- R7: `aligned` is low after reset until the first in-band window. It goes low when any window ends outside the band.
- R8: `step_total` is a two's-complement count of the steps issued (+1 for each later step, −1 for each earlier step) and changes on no other cycle.
- R9: `step_total` stays within ±SHIFT_LIM. A step that would pass the limit is suppressed: no `ps_step` is pulsed and the total holds.
- R10: Synchronous reset clears the window count, the accumulator, `step_total` and `aligned`, and holds `ps_step` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal (steered) clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_sample | input | 1 | Reference clock sampled by the internal clock |
| ps_done | input | 1 | Clock manager reports the requested step is complete |
| ps_step | output | 1 | One-cycle request for a single phase step |
| ps_later | output | 1 | Step direction: 1 later edge, 0 earlier edge |
| aligned | output | 1 | Last window ended inside the balanced band |
| step_total | output | SH_W | Signed net number of steps applied |

## Verification
The bench drives the sample input with a pattern that repeats every window length and holds k high cycles, for every k from zero to the full window. This pins the count of every window regardless of where the window starts. Each value of k separates the three outcomes at the band edges: one below the low threshold, the two inclusive bounds, and one above the high threshold. Solid-high and solid-low patterns run long enough to reach both saturation limits. A withheld done strobe shows that the block stalls after a step, and stray done strobes during an aligned run show that they are ignored. An in-band pattern switched to an out-of-band one shows the alignment flag dropping.

// File: rtl/phal_pkg.sv
package phal_pkg;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_EARLY = 2'd1,
    STEP_LATE  = 2'd2
  } step_e;

  typedef enum logic {
    ST_MEAS = 1'b0,
    ST_WAIT = 1'b1
  } ctl_state_e;

  // Decide what a finished window asks for.
  function automatic step_e classify(input int count, input int lo, input int hi);
    if (count > hi)      return STEP_EARLY;
    else if (count < lo) return STEP_LATE;
    else                 return STEP_NONE;
  endfunction

  // A step is allowed only if it keeps the total inside +/- lim.
  function automatic logic step_allowed(input step_e kind, input int total, input int lim);
    case (kind)
      STEP_LATE:  return total < lim;
      STEP_EARLY: return total > -lim;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic int next_total(input int total, input step_e kind);
    if (kind == STEP_LATE)       return total + 1;
    else if (kind == STEP_EARLY) return total - 1;
    else                         return total;
  endfunction

endpackage

// File: rtl/phal_sync.sv
module phal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // No reset: the chain flushes itself within STAGES cycles.
  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/phal_window.sv
module phal_window #(
  parameter int WIN_LEN = 1024,
  parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sample,
  output logic             win_end,
  output logic [CNT_W-1:0] win_count
);
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_LEN - 1);

  logic [WIN_W-1:0] pos;
  logic [CNT_W-1:0] acc;

  assign win_end   = run && (pos == LAST);
  assign win_count = acc + {{(CNT_W-1){1'b0}}, sample};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos <= '0;
      acc <= '0;
    end else if (pos == LAST) begin
      pos <= '0;
      acc <= '0;
    end else begin
      pos <= pos + WIN_W'(1);
      acc <= win_count;
    end
  end

  // R1: position never leaves the window
  p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(pos) < WIN_LEN);

  // R6: while stalled, nothing is accumulated
  p_discard_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (acc == '0));

  // R1: accumulator cannot exceed cycles counted so far
  p_acc_bound_r1: assert property (@(posedge clk) disable iff (rst)
    int'(acc) <= int'(pos));
endmodule

// File: rtl/phal_stepper.sv
module phal_stepper
  import phal_pkg::*;
#(
  parameter int SHIFT_LIM = 255,
  parameter int SH_W      = $clog2(SHIFT_LIM + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   win_end,
  input  step_e                  kind,
  input  logic                   ps_done,
  output logic                   ps_step,
  output logic                   ps_later,
  output logic                   aligned,
  output logic                   waiting,
  output logic signed [SH_W-1:0] step_total
);
  ctl_state_e state;
  logic       go;

  assign go      = win_end && step_allowed(kind, int'(step_total), SHIFT_LIM);
  assign waiting = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_MEAS;
      ps_step    <= 1'b0;
      ps_later   <= 1'b0;
      aligned    <= 1'b0;
      step_total <= '0;
    end else begin
      ps_step <= 1'b0;
      case (state)
        ST_MEAS: begin
          if (win_end) begin
            aligned <= (kind == STEP_NONE);
            if (go) begin
              ps_step    <= 1'b1;
              ps_later   <= (kind == STEP_LATE);
              step_total <= SH_W'(next_total(int'(step_total), kind));
              state      <= ST_WAIT;
            end
          end
        end
        default: begin
          if (ps_done) state <= ST_MEAS;
        end
      endcase
    end
  end

  // R5: request is a single-cycle pulse
  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ps_step |=> !ps_step);

  // R6: no new request while the previous one is outstanding
  p_wait_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (waiting && !ps_done) |=> !ps_step);

  // R7: a step implies the last window was out of band
  p_unlock_on_step_r7: assert property (@(posedge clk) disable iff (rst)
    ps_step |-> !aligned);

  // R8: total moves by exactly one in the pulsed direction
  p_total_step_r8: assert property (@(posedge clk) disable iff (rst)
    ps_step |-> int'(step_total) == int'($past(step_total)) + (ps_later ? 1 : -1));

  // R8: total is quiet without a pulse
  p_total_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ps_step |-> $stable(step_total));

  // R9: saturation bound
  p_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(step_total) <= SHIFT_LIM) && (int'(step_total) >= -SHIFT_LIM));
endmodule

// File: rtl/phase_align_ctrl.sv
module phase_align_ctrl
  import phal_pkg::*;
#(
  parameter int WIN_LEN   = 1024,
  parameter int LO_TH     = 448,
  parameter int HI_TH     = 576,
  parameter int SHIFT_LIM = 255,
  parameter int SYNC_LEN  = 2,
  parameter int SH_W      = $clog2(SHIFT_LIM + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ref_sample,
  input  logic                   ps_done,
  output logic                   ps_step,
  output logic                   ps_later,
  output logic                   aligned,
  output logic signed [SH_W-1:0] step_total
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic             sample_s;
  logic             win_end;
  logic [CNT_W-1:0] win_count;
  logic             waiting;
  step_e            kind;

  phal_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .d   (ref_sample),
    .q   (sample_s)
  );

  phal_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .run       (!waiting),
    .sample    (sample_s),
    .win_end   (win_end),
    .win_count (win_count)
  );

  assign kind = classify(int'(win_count), LO_TH, HI_TH);

  phal_stepper #(.SHIFT_LIM(SHIFT_LIM), .SH_W(SH_W)) u_step (
    .clk        (clk),
    .rst        (rst),
    .win_end    (win_end),
    .kind       (kind),
    .ps_done    (ps_done),
    .ps_step    (ps_step),
    .ps_later   (ps_later),
    .aligned    (aligned),
    .waiting    (waiting),
    .step_total (step_total)
  );

  // R2: high count with headroom gives an earlier step
  p_early_r2: assert property (@(posedge clk) disable iff (rst)
    (win_end && int'(win_count) > HI_TH && int'(step_total) > -SHIFT_LIM)
      |=> (ps_step && !ps_later));

  // R3: low count with headroom gives a later step
  p_late_r3: assert property (@(posedge clk) disable iff (rst)
    (win_end && int'(win_count) < LO_TH && int'(step_total) < SHIFT_LIM)
      |=> (ps_step && ps_later));

  // R4: in-band window locks and does not step
  p_band_r4: assert property (@(posedge clk) disable iff (rst)
    (win_end && int'(win_count) >= LO_TH && int'(win_count) <= HI_TH)
      |=> (aligned && !ps_step));

  // R10: reset leaves a quiet, cleared output
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!ps_step && !aligned && step_total == '0));
endmodule

// File: tb/tb_phase_align_ctrl.sv
module tb_phase_align_ctrl;
  localparam int W    = 16;
  localparam int LO   = 7;
  localparam int HI   = 9;
  localparam int LIM  = 3;
  localparam int SH_W = $clog2(LIM + 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_sample = 1'b0;
  logic ps_done = 1'b0;
  logic ps_step, ps_later, aligned;
  logic signed [SH_W-1:0] step_total;

  int compared = 0;
  int mismatched = 0;
  int k = 0;
  int phase = 0;
  bit auto_done = 1'b1;
  bit stray_done = 1'b0;
  int done_timer = 0;
  int stray_timer = 0;
  int step_cnt = 0;
  int run_len = 0;
  int run_max = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  phase_align_ctrl #(.WIN_LEN(W), .LO_TH(LO), .HI_TH(HI), .SHIFT_LIM(LIM)) dut (
    .clk(clk), .rst(rst), .ref_sample(ref_sample), .ps_done(ps_done),
    .ps_step(ps_step), .ps_later(ps_later), .aligned(aligned), .step_total(step_total)
  );

  // Stimulus, done responder and pulse monitor, all at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      ref_sample = (phase < k);
      phase = (phase + 1) % W;
      if (ps_step) begin
        step_cnt++;
        run_len++;
        if (run_len > run_max) run_max = run_len;
        if (auto_done) done_timer = 3;
      end else begin
        run_len = 0;
      end
      ps_done = 1'b0;
      if (done_timer > 0) begin
        done_timer--;
        if (done_timer == 0) ps_done = 1'b1;
      end
      if (stray_done) begin
        stray_timer++;
        if (stray_timer % 5 == 0) ps_done = 1'b1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int new_k);
    k = new_k;
    rst = 1'b1;
    wait_cyc(6);
    step_cnt = 0;
    run_max = 0;
    rst = 1'b0;
  endtask

  initial begin
    // R10 / R7: reset state
    do_reset(0);
    rst = 1'b1;
    wait_cyc(1);
    check("R10 ps_step", int'(ps_step), 0);
    check("R7 aligned after reset", int'(aligned), 0);
    check("R10 step_total", int'(step_total), 0);

    // R1..R4: sweep every count of high samples for the first window
    for (int kk = 0; kk <= W; kk++) begin
      int exp_step, exp_dir, exp_tot, exp_lock;
      do_reset(kk);
      wait_cyc(W + 4);
      if (kk > HI)      begin exp_step = 1; exp_dir = 0; exp_tot = -1; exp_lock = 0; end
      else if (kk < LO) begin exp_step = 1; exp_dir = 1; exp_tot = 1;  exp_lock = 0; end
      else              begin exp_step = 0; exp_dir = 0; exp_tot = 0;  exp_lock = 1; end
      check($sformatf("R1 steps k=%0d", kk), step_cnt, exp_step);
      if (exp_step == 1) begin
        if (exp_dir == 0) check($sformatf("R2 dir k=%0d", kk), int'(ps_later), 0);
        else              check($sformatf("R3 dir k=%0d", kk), int'(ps_later), 1);
      end
      check($sformatf("R8 total k=%0d", kk), int'(step_total), exp_tot);
      check($sformatf("R4 aligned k=%0d", kk), int'(aligned), exp_lock);
    end

    // R9: saturation at the early limit
    do_reset(W);
    wait_cyc(12 * (W + 6));
    check("R9 total early limit", int'(step_total), -LIM);
    check("R9 steps early", step_cnt, LIM);
    check("R5 pulse width", run_max, 1);
    check("R7 aligned out of band", int'(aligned), 0);

    // R9: saturation at the late limit
    do_reset(0);
    wait_cyc(12 * (W + 6));
    check("R9 total late limit", int'(step_total), LIM);
    check("R9 steps late", step_cnt, LIM);
    check("R3 direction late", int'(ps_later), 1);

    // R10: reset mid-run clears a saturated total
    rst = 1'b1;
    wait_cyc(2);
    check("R10 total cleared", int'(step_total), 0);
    check("R10 ps_step low", int'(ps_step), 0);

    // R6: no done strobe -> stall after one step
    auto_done = 1'b0;
    do_reset(0);
    wait_cyc(6 * (W + 6));
    check("R6 stalled steps", step_cnt, 1);
    check("R6 stalled total", int'(step_total), 1);
    auto_done = 1'b1;
    done_timer = 1;
    wait_cyc(W + 8);
    check("R6 resumes after done", step_cnt, 2);

    // R6: stray done strobes while aligned are ignored
    do_reset(8);
    stray_done = 1'b1;
    wait_cyc(6 * W);
    stray_done = 1'b0;
    check("R6 stray steps", step_cnt, 0);
    check("R6 stray aligned", int'(aligned), 1);
    check("R6 stray total", int'(step_total), 0);

    // R7: aligned falls when the pattern leaves the band
    k = W;
    wait_cyc(2 * W + 4);
    check("R7 aligned drop", int'(aligned), 0);
    check("R2 early after drop", int'(ps_later), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule